// File: doc/BRIEF.md
# Paged Path Overhead Insertion Register Bank

This block stores the path overhead bytes that a transmitter inserts into outgoing frames: the trace byte, signal label, user channel, multiframe indicator, the three growth/APS/tandem bytes and a two-bit size field. It keeps one set for each port and time slot. A host reaches all of these sets through one small window of addresses. First the host writes a page register that names a port and a time slot. Later writes to the eight insertion addresses then land in that page, and host reads return that page's values. A separate transmit fetch port reads a whole page, chosen by its own port and slot index, without touching the host's page selection.

Which port/slot pairs are legal depends on a configuration mode input:
- One concatenated signal: port 0 with slot 1 only.
- Four tributaries inside one signal: port 0 with slots 1 to 4.
- Four independent ports: any port with slot 1. Two mode codes give this case, one for each line rate.

A page write that names an illegal pair sets a sticky error flag and leaves the previous selection in place. While the flag is set, insertion writes are dropped. The next legal page write clears the flag.

Handshake rules:
- The host bus is a plain synchronous strobe interface.
- The fetch port has a request valid and a response valid and no ready. The response arrives exactly one cycle after the request, and the consumer must take it in that cycle. There is no back-pressure.
- The fetch port can issue one request per cycle.

Top module: `poh_page_bank`

## Requirements
- R1: After reset, every page holds 0x00 in all lanes except the signal label lane (lane 1), which holds 0x01. The page register reads 0x10, meaning port 0, slot 1, error flag clear.
- R2: The page register is at address 0x0AC6, with port in bits 3:0, slot number in bits 6:4 and the error flag in bit 7 (read-only). A legal page write updates port and slot and clears the flag. Reading the register returns {flag, slot, port}.
- R3: A write to address 0x0AD0+k (k = 0..7) stores the data in lane k of the selected page only. The lanes are 0 trace, 1 signal label, 2 user channel, 3 multiframe indicator, 4 growth, 5 APS/growth, 6 tandem, 7 size bits. All other pages keep their contents.
- R4: A port/slot pair is legal only under these rules. Every pair needs port < 4 and slot in 1..4. Mode 0 accepts only port 0 with slot 1. Mode 1 accepts port 0 with any slot 1..4. Modes 2 and 3 accept any port with slot 1.
- R5: An illegal page write sets the error flag and keeps the previous port and slot. Insertion writes are ignored while the flag is set.
- R6: Lane 7 keeps only the two low bits of written data. Its bits 7:2 always read 0.
- R7: A fetch request (tx_req_valid with tx_port and 0-based tx_slot) produces tx_rsp_valid and the page's eight lanes on tx_poh exactly one cycle later, with lane k in bits 8k+7:8k. tx_rsp_valid is low in any cycle that does not follow a request.
- R8: A host read returns data with cpu_rvalid one cycle after cpu_rd. Addresses outside 0x0AC6 and 0x0AD0..0x0AD7 read 0, and writes to them change nothing.
- R9: If a mode change makes the held page illegal, insertion writes are ignored and the error flag stays clear until a legal page is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Port configuration mode (0 single, 1 tributaries, 2/3 quad ports) |
| cpu_we | input | 1 | Host write strobe |
| cpu_rd | input | 1 | Host read strobe |
| cpu_addr | input | 12 | Host address |
| cpu_wdata | input | 8 | Host write data |
| cpu_rdata | output | 8 | Host read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Host read data valid, one cycle after cpu_rd |
| tx_req_valid | input | 1 | Transmit fetch request |
| tx_port | input | 2 | Transmit fetch port index |
| tx_slot | input | 2 | Transmit fetch slot index, 0-based |
| tx_rsp_valid | output | 1 | Transmit fetch response valid |
| tx_poh | output | 64 | Fetched page, lane k in bits 8k+7:8k |

## Verification
The bound checker checks these on every cycle:
- The one-cycle latency of both read paths, and that no response appears without a request.
- That the size lane's upper bits stay zero.
- That each page write drives the error flag the right way, with the selection frozen after an illegal write. The checker decides legality with its own mode-by-mode rule.

The following can only be shown by the bench's sweeps:
- Where data lands among the pages, and that the other pages are untouched.
- That writes are dropped under the sticky flag or after a mode change, and that unmapped addresses are inert.

The bench shows these by sweeping every mode and page field code, and by reading every page back through the fetch port.

// File: rtl/poh_pkg.sv
package poh_pkg;

  localparam int NLANES = 8;
  localparam logic [11:0] PAGE_ADDR = 12'hAC6;
  localparam logic [11:0] LANE_BASE = 12'hAD0;

  typedef enum logic [1:0] {
    CFG_SINGLE = 2'd0,
    CFG_TRIB   = 2'd1,
    CFG_QUAD_A = 2'd2,
    CFG_QUAD_B = 2'd3
  } cfg_mode_e;

  typedef enum logic [2:0] {
    LANE_TRACE = 3'd0,
    LANE_LABEL = 3'd1,
    LANE_USER  = 3'd2,
    LANE_MFI   = 3'd3,
    LANE_GROW  = 3'd4,
    LANE_APS   = 3'd5,
    LANE_TAND  = 3'd6,
    LANE_SIZE  = 3'd7
  } lane_e;

  // Legality of a port / 1-based slot pair under a configuration mode (R4)
  function automatic logic page_legal(cfg_mode_e m, int unsigned port,
                                      int unsigned slot, int unsigned nports,
                                      int unsigned nslots);
    if (port >= nports || slot == 0 || slot > nslots) return 1'b0;
    case (m)
      CFG_SINGLE: return (port == 0) && (slot == 1);
      CFG_TRIB:   return (port == 0);
      default:    return (slot == 1);
    endcase
  endfunction

endpackage

// File: rtl/poh_page_ctl.sv
module poh_page_ctl
  import poh_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int SLOTS = 4,
  parameter int PW    = 2,
  parameter int SFW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode,
  input  logic           wr,
  input  logic [6:0]     wdata,
  output logic [PW-1:0]  sel_port,
  output logic [SFW-1:0] sel_slot,
  output logic           err,
  output logic           wr_allow
);

  logic [3:0] f_port;
  logic [2:0] f_slot;
  logic       new_ok;

  assign f_port = wdata[3:0];
  assign f_slot = wdata[6:4];
  assign new_ok = page_legal(cfg_mode_e'(mode), int'(f_port), int'(f_slot),
                             PORTS, SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_port <= '0;
      sel_slot <= SFW'(1);
      err      <= 1'b0;
    end else if (wr) begin
      if (new_ok) begin
        sel_port <= PW'(f_port);
        sel_slot <= SFW'(f_slot);
        err      <= 1'b0;
      end else begin
        err      <= 1'b1;
      end
    end
  end

  // Held page must still be legal under the present mode (R9)
  assign wr_allow = !err && page_legal(cfg_mode_e'(mode), int'(sel_port),
                                       int'(sel_slot), PORTS, SLOTS);

endmodule

// File: rtl/poh_page_store.sv
module poh_page_store
  import poh_pkg::*;
#(
  parameter int PAGES = 16,
  parameter int PGW   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [PGW-1:0]        wpage,
  input  logic [2:0]            wlane,
  input  logic [7:0]            wdata,
  input  logic [PGW-1:0]        rpage_a,
  input  logic [2:0]            rlane_a,
  output logic [7:0]            rbyte_a,
  input  logic [PGW-1:0]        rpage_b,
  output logic [8*NLANES-1:0]   rdata_b
);

  logic [7:0] mem [PAGES][NLANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int pg = 0; pg < PAGES; pg++)
        for (int ln = 0; ln < NLANES; ln++)
          mem[pg][ln] <= (ln == int'(LANE_LABEL)) ? 8'h01 : 8'h00;
    end else if (we) begin
      mem[wpage][wlane] <= (wlane == LANE_SIZE) ? (wdata & 8'h03) : wdata;
    end
  end

  assign rbyte_a = mem[rpage_a][rlane_a];

  for (genvar ln = 0; ln < NLANES; ln++) begin : g_lane
    assign rdata_b[8*ln +: 8] = mem[rpage_b][ln];
  end

endmodule

// File: rtl/poh_tx_fetch.sv
module poh_tx_fetch #(
  parameter int PW = 2,
  parameter int SW = 2,
  parameter int BW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PW-1:0]    req_port,
  input  logic [SW-1:0]    req_slot,
  output logic [PW+SW-1:0] page_idx,
  input  logic [BW-1:0]    page_data,
  output logic             rsp_valid,
  output logic [BW-1:0]    rsp_data
);

  assign page_idx = {req_port, req_slot};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_data <= page_data;
    end
  end

endmodule

// File: rtl/poh_page_bank.sv
module poh_page_bank
  import poh_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int SLOTS = 4,
  parameter int AW    = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  cfg_mode,
  input  logic                        cpu_we,
  input  logic                        cpu_rd,
  input  logic [AW-1:0]               cpu_addr,
  input  logic [7:0]                  cpu_wdata,
  output logic [7:0]                  cpu_rdata,
  output logic                        cpu_rvalid,
  input  logic                        tx_req_valid,
  input  logic [$clog2(PORTS)-1:0]    tx_port,
  input  logic [$clog2(SLOTS)-1:0]    tx_slot,
  output logic                        tx_rsp_valid,
  output logic [8*poh_pkg::NLANES-1:0] tx_poh
);

  localparam int PW    = $clog2(PORTS);
  localparam int SW    = $clog2(SLOTS);
  localparam int SFW   = $clog2(SLOTS + 1);
  localparam int PAGES = PORTS * SLOTS;
  localparam int PGW   = PW + SW;
  localparam int BW    = 8 * NLANES;

  logic           page_hit, lane_hit;
  logic [2:0]     lane_sel;
  logic [PW-1:0]  sel_port;
  logic [SFW-1:0] sel_slot;
  logic           page_err, wr_allow;
  logic [SW-1:0]  sel_idx;
  logic [PGW-1:0] sel_page, tx_page;
  logic [7:0]     lane_byte, page_rb, rd_mux;
  logic [BW-1:0]  tx_page_data;

  assign page_hit = (cpu_addr == AW'(PAGE_ADDR));
  assign lane_hit = ((cpu_addr & ~AW'(7)) == AW'(LANE_BASE));
  assign lane_sel = cpu_addr[2:0];

  poh_page_ctl #(.PORTS(PORTS), .SLOTS(SLOTS), .PW(PW), .SFW(SFW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg_mode),
    .wr       (cpu_we && page_hit),
    .wdata    (cpu_wdata[6:0]),
    .sel_port (sel_port),
    .sel_slot (sel_slot),
    .err      (page_err),
    .wr_allow (wr_allow)
  );

  assign sel_idx  = SW'(sel_slot - SFW'(1));
  assign sel_page = {sel_port, sel_idx};

  poh_page_store #(.PAGES(PAGES), .PGW(PGW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cpu_we && lane_hit && wr_allow),
    .wpage   (sel_page),
    .wlane   (lane_sel),
    .wdata   (cpu_wdata),
    .rpage_a (sel_page),
    .rlane_a (lane_sel),
    .rbyte_a (lane_byte),
    .rpage_b (tx_page),
    .rdata_b (tx_page_data)
  );

  poh_tx_fetch #(.PW(PW), .SW(SW), .BW(BW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (tx_req_valid),
    .req_port  (tx_port),
    .req_slot  (tx_slot),
    .page_idx  (tx_page),
    .page_data (tx_page_data),
    .rsp_valid (tx_rsp_valid),
    .rsp_data  (tx_poh)
  );

  assign page_rb = {page_err, 3'(sel_slot), 4'(sel_port)};

  always_comb begin
    if (page_hit)      rd_mux = page_rb;
    else if (lane_hit) rd_mux = lane_byte;
    else               rd_mux = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= 8'h00;
    end else begin
      cpu_rvalid <= cpu_rd;
      if (cpu_rd) cpu_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/poh_page_bank_chk.sv
module poh_page_bank_chk #(
  parameter int PORTS = 4,
  parameter int SLOTS = 4,
  parameter int AW    = 12,
  parameter int PW    = 2,
  parameter int SFW   = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     cfg_mode,
  input logic           cpu_we,
  input logic           cpu_rd,
  input logic [AW-1:0]  cpu_addr,
  input logic [6:0]     wfield,
  input logic           cpu_rvalid,
  input logic           tx_req_valid,
  input logic           tx_rsp_valid,
  input logic [5:0]     size_hi,
  input logic           page_err,
  input logic [PW-1:0]  sel_port,
  input logic [SFW-1:0] sel_slot
);

  logic       page_wr;
  logic [3:0] fp;
  logic [2:0] fs;
  logic       slot_in_range, field_ok;

  assign page_wr       = cpu_we && (cpu_addr == AW'(12'hAC6));
  assign fp            = wfield[3:0];
  assign fs            = wfield[6:4];
  assign slot_in_range = (fs != 3'd0) && (int'(fs) <= SLOTS);

  always_comb begin
    unique case (cfg_mode)
      2'd0:    field_ok = (fp == 4'd0) && (fs == 3'd1);
      2'd1:    field_ok = (fp == 4'd0) && slot_in_range;
      default: field_ok = (fs == 3'd1) && (int'(fp) < PORTS);
    endcase
  end

  AST_TX_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_valid |=> tx_rsp_valid); // R7
  AST_TX_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req_valid |=> !tx_rsp_valid); // R7
  AST_CPU_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |=> cpu_rvalid); // R8
  AST_CPU_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> !cpu_rvalid); // R8
  AST_SIZE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rsp_valid |-> (size_hi == 6'd0)); // R6
  AST_BAD_PAGE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (page_wr && !field_ok) |=> (page_err && $stable(sel_port) && $stable(sel_slot))); // R5
  AST_GOOD_PAGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (page_wr && field_ok) |=> (!page_err && (sel_slot == SFW'($past(fs))))); // R2

endmodule

bind poh_page_bank poh_page_bank_chk #(
  .PORTS(PORTS), .SLOTS(SLOTS), .AW(AW), .PW(PW), .SFW(SFW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mode     (cfg_mode),
  .cpu_we       (cpu_we),
  .cpu_rd       (cpu_rd),
  .cpu_addr     (cpu_addr),
  .wfield       (cpu_wdata[6:0]),
  .cpu_rvalid   (cpu_rvalid),
  .tx_req_valid (tx_req_valid),
  .tx_rsp_valid (tx_rsp_valid),
  .size_hi      (tx_poh[63:58]),
  .page_err     (page_err),
  .sel_port     (sel_port),
  .sel_slot     (sel_slot)
);

// File: tb/sim_poh_page_bank.sv
module sim_poh_page_bank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cpu_we = 1'b0, cpu_rd = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic        tx_req_valid = 1'b0;
  logic [1:0]  tx_port = '0, tx_slot = '0;
  logic        tx_rsp_valid;
  logic [63:0] tx_poh;

  int total = 0, bad = 0;
  bit done = 0;

  // Bench model built from the requirements
  int exp_mem [16][8];
  int m_port, m_slot, m_err, m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  poh_page_bank u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cpu_we(cpu_we), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .tx_req_valid(tx_req_valid), .tx_port(tx_port), .tx_slot(tx_slot),
    .tx_rsp_valid(tx_rsp_valid), .tx_poh(tx_poh)
  );

  function automatic bit m_legal(int mode, int port, int slot);
    if (port > 3 || slot < 1 || slot > 4) return 0;
    if (mode == 0) return (port == 0) && (slot == 1);
    if (mode == 1) return (port == 0);
    return (slot == 1);
  endfunction

  function automatic logic [63:0] exp_page(int idx);
    logic [63:0] v;
    for (int ln = 0; ln < 8; ln++) v[8*ln +: 8] = 8'(exp_mem[idx][ln]);
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic set_mode(int m);
    @(negedge clk);
    cfg_mode = 2'(m);
    m_mode = m;
  endtask

  task automatic cpu_write(int addr, int data);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 12'(addr); cpu_wdata = 8'(data);
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0;
    if (addr == 'hAC6) begin
      if (m_legal(m_mode, data & 15, (data >> 4) & 7)) begin
        m_port = data & 15; m_slot = (data >> 4) & 7; m_err = 0;
      end else m_err = 1;
    end else if (addr >= 'hAD0 && addr <= 'hAD7) begin
      if (!m_err && m_legal(m_mode, m_port, m_slot))
        exp_mem[m_port*4 + m_slot - 1][addr - 'hAD0] = (addr == 'hAD7) ? (data & 3) : (data & 255);
    end
  endtask

  task automatic cpu_read(int addr, output logic [7:0] d, output logic v);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 12'(addr);
    @(posedge clk);
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata; v = cpu_rvalid;
  endtask

  task automatic tx_fetch(int p, int s, output logic [63:0] d, output logic v);
    @(negedge clk);
    tx_req_valid = 1'b1; tx_port = 2'(p); tx_slot = 2'(s);
    @(posedge clk);
    @(negedge clk);
    tx_req_valid = 1'b0;
    d = tx_poh; v = tx_rsp_valid;
  endtask

  task automatic sweep_pages(string tag);
    logic [63:0] d; logic v;
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++) begin
        tx_fetch(p, s, d, v);
        check(v && d == exp_page(p*4 + s), tag, d, exp_page(p*4 + s));
      end
  endtask

  task automatic expect_page_reg(string tag);
    logic [7:0] d; logic v;
    logic [7:0] e;
    e = 8'((m_err << 7) | (m_slot << 4) | m_port);
    cpu_read('hAC6, d, v);
    check(v && d == e, tag, 64'(d), 64'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic v; logic [63:0] q;
    for (int i = 0; i < 16; i++)
      for (int ln = 0; ln < 8; ln++) exp_mem[i][ln] = (ln == 1) ? 1 : 0;
    m_port = 0; m_slot = 1; m_err = 0; m_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset contents and page register
    sweep_pages("R1 reset page contents");
    expect_page_reg("R1 reset page register");

    // R7: no response without a request
    @(negedge clk);
    check(!tx_rsp_valid, "R7 idle rsp_valid low", 64'(tx_rsp_valid), 64'd0);
    tx_fetch(0, 0, q, v);
    check(v == 1'b1, "R7 rsp one cycle after req", 64'(v), 64'd1);
    @(negedge clk);
    check(!tx_rsp_valid, "R7 rsp drops after single req", 64'(tx_rsp_valid), 64'd0);

    // R4 / R5 / R2: sweep every mode and page field code
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      for (int pf = 0; pf < 8; pf++)
        for (int sf = 0; sf < 8; sf++) begin
          cpu_write('hAC6, 'h10);
          cpu_write('hAC6, (sf << 4) | pf);
          expect_page_reg(m_legal(m, pf, sf) ? "R4 R2 legal page accepted" : "R4 R5 illegal page flagged");
        end
    end

    // R3 / R6 / R8: fill tributary pages, read each lane back
    set_mode(1);
    for (int s = 1; s <= 4; s++) begin
      cpu_write('hAC6, s << 4);
      for (int ln = 0; ln < 8; ln++) begin
        cpu_write('hAD0 + ln, (s*37 + ln*11 + 5) & 255);
        cpu_read('hAD0 + ln, d, v);
        check(v && d == 8'(exp_mem[s-1][ln]), "R3 R8 lane readback", 64'(d), 64'(exp_mem[s-1][ln]));
      end
    end
    set_mode(2);
    for (int p = 1; p < 4; p++) begin
      cpu_write('hAC6, 'h10 | p);
      for (int ln = 0; ln < 8; ln++) cpu_write('hAD0 + ln, (p*53 + ln*7 + 200) & 255);
    end
    sweep_pages("R3 page isolation sweep");

    // R6: size lane keeps two bits
    cpu_write('hAD7, 'hFF);
    cpu_read('hAD7, d, v);
    check(d == 8'h03, "R6 size lane masked", 64'(d), 64'h03);
    cpu_write('hAD7, 'hFE);
    cpu_read('hAD7, d, v);
    check(d == 8'h02, "R6 size lane masked", 64'(d), 64'h02);

    // R5: sticky flag blocks writes until a legal page
    set_mode(0);
    cpu_write('hAC6, 'h11);
    expect_page_reg("R5 flag set on illegal page");
    cpu_write('hAD0, 'hEE);
    cpu_write('hAC6, 'h03);
    expect_page_reg("R5 flag stays after second illegal page");
    cpu_write('hAD3, 'h5A);
    sweep_pages("R5 writes ignored while flagged");
    cpu_write('hAC6, 'h10);
    expect_page_reg("R5 R2 flag cleared by legal page");
    cpu_write('hAD0, 'hEE);
    tx_fetch(0, 0, q, v);
    check(q[7:0] == 8'hEE, "R5 write lands after recovery", 64'(q[7:0]), 64'hEE);

    // R9: mode change makes held page illegal
    set_mode(1);
    cpu_write('hAC6, 'h30);
    set_mode(0);
    cpu_write('hAD2, 'h77);
    expect_page_reg("R9 flag clear after mode change");
    tx_fetch(0, 2, q, v);
    check(q == exp_page(2), "R9 write ignored on stale page", q, exp_page(2));
    set_mode(1);
    cpu_write('hAD2, 'h77);
    tx_fetch(0, 2, q, v);
    check(q[23:16] == 8'h77, "R9 write accepted once legal again", 64'(q[23:16]), 64'h77);

    // R8: unmapped addresses
    cpu_write('hAC7, 'h55);
    cpu_write('hAD8, 'h55);
    cpu_write('hACF, 'h55);
    cpu_write('h000, 'h55);
    cpu_read('hAC7, d, v);
    check(v && d == 8'h00, "R8 unmapped read zero", 64'(d), 64'h00);
    cpu_read('hAD8, d, v);
    check(v && d == 8'h00, "R8 unmapped read zero", 64'(d), 64'h00);
    cpu_read('h000, d, v);
    check(v && d == 8'h00, "R8 unmapped read zero", 64'(d), 64'h00);
    @(negedge clk);
    check(!cpu_rvalid, "R8 rvalid low without read", 64'(cpu_rvalid), 64'd0);
    sweep_pages("R8 unmapped writes inert");
    expect_page_reg("R8 page register unchanged");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule